// File: doc/BRIEF.md
# Dual-Half Character Display Enable Sequencer

This block generates the two enable strobes of a character display built from two controllers, one per half of the screen. Two level inputs, one per half, come from select latches set by the host. A third level, the write flag, tells whether the access is a write or a read. All three are asynchronous to the block clock and pass through a synchronizer of configurable depth. While idle the block polls the synchronized selects. When exactly one goes high, it serves that half. For a write it issues one enable pulse of fixed width and then waits. For a read it raises the enable and keeps it high, so the display can drive the shared data bus. In both cases it goes back to polling only when both selects have dropped.

A busy output stays high from the moment a selection is taken until the block is polling again. The host uses it to know when it may change the write flag or the bus data. The register-select control is passed straight through to the display. If both selects are seen high in the same cycle, the block drives neither enable and waits for both to drop. All pins are plain levels, and there is no streaming data path.

Top module: `dual_disp_enable_seq`

## Requirements
- R1: After reset, en_a_o and en_b_o are 0 and busy_o is 0.
- R2: rs_o equals rs_i at all times, with no clock delay.
- R3: A write is a sel_a_i rise (with sel_b_i low) while wr_i is 1. It makes en_a_o high for exactly PULSE_CYCLES consecutive cycles. The first high sample comes SYNC_STAGES+1 rising edges after the select rises, and en_b_o stays 0 throughout.
- R4: A write on half B (sel_b_i rising, sel_a_i low, wr_i 1) gives the same single pulse on en_b_o, with en_a_o staying 0.
- R5: After a write pulse, no further pulse occurs while any select stays high. busy_o stays 1 until both selects are low. It falls SYNC_STAGES+1 rising edges after the last select drops.
- R6: A read is a single select rise while wr_i is 0. It raises the matching enable SYNC_STAGES+1 edges after the select rises and holds it high continuously while the select stays high. The enable drops SYNC_STAGES+1 edges after both selects are low, and busy_o drops in the same cycle.
- R7: If both selects are first seen high in the same cycle, neither enable is ever raised. busy_o is 1 until both selects are low, including while only one of them remains high.
- R8: busy_o is 1 whenever either enable is 1. After busy_o returns to 0, a new selection is served normally.
- R9: en_a_o and en_b_o are never 1 in the same cycle.
- R10: wr_i is sampled only when a selection is taken. Toggling it during a read hold leaves the enable high and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_a_i | input | 1 | Select latch level for display half A (asynchronous) |
| sel_b_i | input | 1 | Select latch level for display half B (asynchronous) |
| wr_i | input | 1 | Write latch level: 1 write, 0 read (asynchronous) |
| rs_i | input | 1 | Register-select control from host |
| en_a_o | output | 1 | Enable strobe for display half A |
| en_b_o | output | 1 | Enable strobe for display half B |
| rs_o | output | 1 | Register-select to display, copy of rs_i |
| busy_o | output | 1 | High from selection until polling resumes |

## Verification
The bench builds the block with PULSE_CYCLES = 6 and SYNC_STAGES = 3. Both differ from the defaults, so an off-by-one in the pulse counter or a latency that ignores the synchronizer depth shows up as a wrong count. With six cycles of pulse there is room to see that the pulse neither stretches nor repeats while a select stays high. The three-stage synchronizer makes both the rise latency and the release latency four edges, which the bench samples at the exact cycle. The conflict case and a read with the write flag toggled mid-hold reach the paths where a selection must not produce any enable, or must not produce a pulse.

// File: rtl/dde_pkg.sv
package dde_pkg;
  typedef enum logic [1:0] {
    ST_POLL  = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_WAIT  = 2'd3
  } dde_state_e;

  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } dde_half_e;
endpackage

// File: rtl/dde_sync.sv
module dde_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dde_timer.sv
module dde_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  assert_no_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !start_i);
  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dde_fsm.sv
module dde_fsm
  import dde_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic wr_i,
  input  logic done_i,
  output logic start_o,
  output logic en_a_o,
  output logic en_b_o,
  output logic busy_o
);
  dde_state_e state_q, state_d;
  dde_half_e  half_q, half_d;
  logic       any_sel;
  logic       one_sel;
  logic       drive;

  assign any_sel = sel_a_i | sel_b_i;
  assign one_sel = sel_a_i ^ sel_b_i;

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_POLL: begin
        if (one_sel) begin
          half_d = sel_b_i ? HALF_B : HALF_A;
          if (wr_i) begin
            state_d = ST_PULSE;
            start_o = 1'b1;
          end else begin
            state_d = ST_HOLD;
          end
        end else if (sel_a_i && sel_b_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_PULSE: if (done_i)   state_d = ST_WAIT;
      ST_HOLD:  if (!any_sel) state_d = ST_POLL;
      ST_WAIT:  if (!any_sel) state_d = ST_POLL;
      default:                state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POLL;
      half_q  <= HALF_A;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  assign drive  = (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign en_a_o = drive && (half_q == HALF_A);
  assign en_b_o = drive && (half_q == HALF_B);
  assign busy_o = (state_q != ST_POLL);

  assert_hold_until_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HOLD) && any_sel) |=> (en_a_o || en_b_o));
  assert_conflict_no_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_POLL) && sel_a_i && sel_b_i) |=> !(en_a_o || en_b_o));
  assert_release_to_poll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !any_sel) |=> !busy_o);
  assert_pulse_ends_in_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_PULSE) && done_i) |=> (!en_a_o && !en_b_o && busy_o));
endmodule

// File: rtl/dual_disp_enable_seq.sv
module dual_disp_enable_seq #(
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic wr_i,
  input  logic rs_i,
  output logic en_a_o,
  output logic en_b_o,
  output logic rs_o,
  output logic busy_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn_in;
  logic             tmr_start;
  logic             tmr_done;

  assign raw_in = {wr_i, sel_b_i, sel_a_i};

  dde_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn_in)
  );

  dde_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  dde_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_a_i (syn_in[0]),
    .sel_b_i (syn_in[1]),
    .wr_i    (syn_in[2]),
    .done_i  (tmr_done),
    .start_o (tmr_start),
    .en_a_o  (en_a_o),
    .en_b_o  (en_b_o),
    .busy_o  (busy_o)
  );

  assign rs_o = rs_i;

  assert_one_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_a_o && en_b_o));
  assert_enable_needs_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_o || en_b_o) |-> busy_o);
endmodule

// File: tb/dual_disp_enable_seq_tb.sv
`timescale 1ns/1ps
module dual_disp_enable_seq_tb;
  localparam int P = 6;
  localparam int S = 3;
  localparam int LAT = S + 1;

  logic clk = 0, rst_n = 0;
  logic sel_a = 0, sel_b = 0, wr = 0, rs = 0;
  logic en_a, en_b, rs_out, busy;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  dual_disp_enable_seq #(.PULSE_CYCLES(P), .SYNC_STAGES(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .wr_i(wr), .rs_i(rs), .en_a_o(en_a), .en_b_o(en_b),
    .rs_o(rs_out), .busy_o(busy)
  );

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Drop all selects and check busy falls exactly LAT edges later (R5)
  task automatic release_all(string req);
    @(negedge clk); sel_a = 0; sel_b = 0;
    repeat (S) @(negedge clk);
    check(req, "busy just before release latency", busy, 1);
    @(negedge clk);
    check(req, "busy after release latency", busy, 0);
    check(req, "enables after release", int'(en_a | en_b), 0);
  endtask

  task automatic t_reset();
    check("R1", "en_a at reset", en_a, 0);
    check("R1", "en_b at reset", en_b, 0);
    check("R1", "busy at reset", busy, 0);
  endtask

  task automatic t_rs();
    for (int i = 0; i < 4; i++) begin
      rs = i[0]; #1;
      check("R2", "rs passthrough", rs_out, int'(rs));
    end
    rs = 0;
  endtask

  task automatic t_write(bit half_b, string req);
    int first = -1, width = 0, rises = 0, other = 0, both = 0;
    logic prev = 0, cur;
    @(negedge clk); wr = 1; if (half_b) sel_b = 1; else sel_a = 1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      cur = half_b ? en_b : en_a;
      if (cur) begin width++; if (first < 0) first = k; end
      if (cur && !prev) rises++;
      if (half_b ? en_a : en_b) other++;
      if (en_a && en_b) both++;
      prev = cur;
    end
    check(req, "pulse first cycle", first, LAT);
    check(req, "pulse width", width, P);
    check("R5", "pulse count while select held", rises, 1);
    check(req, "other enable high count", other, 0);
    check("R9", "both enables high count", both, 0);
    check("R5", "busy while select held", busy, 1);
    release_all("R5");
  endtask

  task automatic t_read(bit half_b);
    int lows = 0, pulses = 0;
    logic prev = 1, cur;
    @(negedge clk); wr = 0; if (half_b) sel_b = 1; else sel_a = 1;
    repeat (S) @(negedge clk);
    check("R6", "enable before latency", int'(half_b ? en_b : en_a), 0);
    @(negedge clk);
    check("R6", "enable at latency", int'(half_b ? en_b : en_a), 1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 5)  wr = 1;
      if (k == 12) wr = 0;
      cur = half_b ? en_b : en_a;
      if (!cur) lows++;
      if (cur && !prev) pulses++;
      prev = cur;
    end
    check("R6", "enable low samples during hold", lows, 0);
    check("R10", "extra rises after wr toggle", pulses, 0);
    @(negedge clk); sel_a = 0; sel_b = 0;
    repeat (S) @(negedge clk);
    check("R6", "enable before release latency", int'(half_b ? en_b : en_a), 1);
    @(negedge clk);
    check("R6", "enable after release", int'(half_b ? en_b : en_a), 0);
    check("R6", "busy after release", busy, 0);
  endtask

  task automatic t_conflict();
    int en_seen = 0;
    @(negedge clk); wr = 1; sel_a = 1; sel_b = 1;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (en_a || en_b) en_seen++;
    end
    check("R7", "busy on conflict", busy, 1);
    sel_a = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (en_a || en_b) en_seen++;
    end
    check("R7", "busy with one select left", busy, 1);
    check("R7", "enable samples in conflict", en_seen, 0);
    release_all("R7");
  endtask

  task automatic t_busy_tracks();
    int bad = 0;
    @(negedge clk); wr = 0; sel_b = 1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if ((en_a || en_b) && !busy) bad++;
    end
    check("R8", "enable without busy", bad, 0);
    check("R8", "busy during read", busy, 1);
    release_all("R8");
  endtask

  initial begin
    #200_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rs();
    t_write(1'b0, "R3");
    t_write(1'b1, "R4");
    t_read(1'b0);
    t_read(1'b1);
    t_conflict();
    t_write(1'b0, "R8");
    t_busy_tracks();
    repeat (5) @(negedge clk);
    report();
  end
endmodule